// File: doc/BRIEF.md
# Opcode-to-Control Decoder for a 16-bit Load/Store Core

This block turns the 4-bit operation field of a 16-bit instruction into the control word that steers a small single-cycle datapath. It is purely combinational and holds no state. From the opcode it decides whether a register is written and from which source, which ALU function is used and whether the ALU's second operand is the sign-extended 8-bit immediate or the second source register. It also decides whether data memory is written, which conditional branch or jump is taken, and whether the instruction links.

The destination-register field of the instruction also enters the block. For the linking jump the block replaces that field with a fixed link register. For every other instruction the field passes through unchanged. The block also reports the encoding format of the instruction: register, immediate or jump. Two opcode values are unassigned. They raise an illegal flag and decode to a control word that changes nothing.

Top module: `isa_ctl_decoder`

## Requirements
- R1: `illegal_o` is 1 for opcodes 0x7 and 0xC and 0 for the other fourteen opcodes.
- R2: for an illegal opcode, `reg_we_o`=0, `mem_we_o`=0, `br_o`=0, `jmp_o`=0, `link_o`=0, `wsrc_o`=0, `alu_op_o`=0, `b_imm_o`=0 and `fmt_o`=0.
- R3: `reg_we_o` is 1 exactly for opcodes 0x0 add, 0x1 sub, 0x2 load, 0x4 and, 0x5 or, 0x6 not, 0x8 add-immediate, 0x9 load-upper and 0xD jump-and-link. It is 0 for 0x3 store, 0xA, 0xB, 0xE and 0xF.
- R4: `wsrc_o` is 1 (memory) for 0x2, 3 (upper-immediate merge) for 0x9, 2 (PC+1) for 0xD, and 0 (ALU) for every other opcode.
- R5: `alu_op_o` is 1 (subtract) for 0x1, 2 (AND) for 0x4, 3 (OR) for 0x5 and 4 (NOT) for 0x6. It is 0 (add) for every other opcode, which includes the address add of load 0x2 and store 0x3.
- R6: `b_imm_o` is 1 (sign-extended imm8 as ALU operand B) only for 0x8. It is 0 (rt) for every other opcode.
- R7: `mem_we_o` is 1 only for 0x3.
- R8: `br_o` is 1 (taken when the register is zero) for 0xA, 2 (taken when the register is nonzero) for 0xB, and 0 otherwise.
- R9: `jmp_o` is 1 (PC-relative imm8) for 0xD, 2 (PC-relative imm12) for 0xF, 3 (register target) for 0xE, and 0 otherwise.
- R10: `link_o` is 1 only for 0xD. `wr_idx_o` equals register 1 for 0xD and equals `rd_i` for every other opcode.
- R11: `fmt_o` is 1 (I) for 0x8, 0x9, 0xA, 0xB and 0xD, 2 (J) for 0xF, and 0 (R) for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 4 | Instruction operation field |
| rd_i | input | 4 | Instruction destination-register field |
| illegal_o | output | 1 | Opcode is unassigned |
| reg_we_o | output | 1 | Register file write enable |
| wsrc_o | output | 2 | Write-data source: 0 ALU, 1 memory, 2 PC+1, 3 upper-immediate merge |
| wr_idx_o | output | 4 | Register index to write |
| link_o | output | 1 | Instruction saves the return address |
| alu_op_o | output | 3 | ALU function: 0 add, 1 sub, 2 and, 3 or, 4 not |
| b_imm_o | output | 1 | ALU operand B is the sign-extended imm8 |
| mem_we_o | output | 1 | Data memory write enable |
| br_o | output | 2 | Branch type: 0 none, 1 on zero, 2 on nonzero |
| jmp_o | output | 2 | Jump type: 0 none, 1 rel imm8, 2 rel imm12, 3 register |
| fmt_o | output | 2 | Encoding format: 0 R, 1 I, 2 J |

## Verification
The hardest cases to reach are the two unassigned opcodes and the link-register override. A slip in the override shows only when `rd_i` differs from the link register while the opcode is the jump-and-link. The stimulus therefore sweeps all sixteen opcodes. Each opcode is paired with several destination fields: 0, 1, a middle value and 15. This way every opcode, the illegal ones included, is seen both with and without the override, and every output field is compared on every vector.

// File: rtl/isa_ctl_pkg.sv
package isa_ctl_pkg;

  localparam int OPC_W   = 4;
  localparam int N_INSTR = 14;

  localparam int IX_ADD  = 0;
  localparam int IX_SUB  = 1;
  localparam int IX_LW   = 2;
  localparam int IX_SW   = 3;
  localparam int IX_AND  = 4;
  localparam int IX_OR   = 5;
  localparam int IX_NOT  = 6;
  localparam int IX_ADDI = 7;
  localparam int IX_LDHI = 8;
  localparam int IX_BZ   = 9;
  localparam int IX_BNZ  = 10;
  localparam int IX_JAL  = 11;
  localparam int IX_JR   = 12;
  localparam int IX_J    = 13;

  // opcode value per instruction index; 0x7 and 0xC are unassigned
  localparam logic [OPC_W-1:0] OPC_CODE [N_INSTR] = '{
    4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6,
    4'h8, 4'h9, 4'hA, 4'hB, 4'hD, 4'hE, 4'hF
  };

  typedef logic [N_INSTR-1:0] hit_t;

  typedef enum logic [1:0] {
    WSRC_ALU   = 2'd0,
    WSRC_MEM   = 2'd1,
    WSRC_PC1   = 2'd2,
    WSRC_UPPER = 2'd3
  } wsrc_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_NOT = 3'd4
  } alu_e;

  typedef enum logic [1:0] {
    BR_NONE    = 2'd0,
    BR_ZERO    = 2'd1,
    BR_NONZERO = 2'd2
  } br_e;

  typedef enum logic [1:0] {
    JMP_NONE  = 2'd0,
    JMP_REL8  = 2'd1,
    JMP_REL12 = 2'd2,
    JMP_REG   = 2'd3
  } jmp_e;

  typedef enum logic [1:0] {
    FMT_R = 2'd0,
    FMT_I = 2'd1,
    FMT_J = 2'd2
  } fmt_e;

endpackage

// File: rtl/isa_opclass.sv
module isa_opclass
  import isa_ctl_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output hit_t             hit_o,
  output logic             illegal_o
);

  for (genvar g = 0; g < N_INSTR; g++) begin : g_match
    assign hit_o[g] = (opc_i == OPC_CODE[g]);
  end

  assign illegal_o = ~|hit_o;

endmodule

// File: rtl/isa_wb_ctl.sv
module isa_wb_ctl
  import isa_ctl_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int LINK_REG  = 1
) (
  input  hit_t                 hit_i,
  input  logic [REG_IDX_W-1:0] rd_i,
  output logic                 reg_we_o,
  output wsrc_e                wsrc_o,
  output logic                 link_o,
  output logic [REG_IDX_W-1:0] wr_idx_o
);

  localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

  always_comb begin
    reg_we_o = hit_i[IX_ADD] | hit_i[IX_SUB] | hit_i[IX_LW]  |
               hit_i[IX_AND] | hit_i[IX_OR]  | hit_i[IX_NOT] |
               hit_i[IX_ADDI] | hit_i[IX_LDHI] | hit_i[IX_JAL];

    wsrc_o = WSRC_ALU;
    if (hit_i[IX_LW])   wsrc_o = WSRC_MEM;
    if (hit_i[IX_LDHI]) wsrc_o = WSRC_UPPER;
    if (hit_i[IX_JAL])  wsrc_o = WSRC_PC1;

    link_o   = hit_i[IX_JAL];
    wr_idx_o = link_o ? LINK_IDX : rd_i;
  end

endmodule

// File: rtl/isa_alu_ctl.sv
module isa_alu_ctl
  import isa_ctl_pkg::*;
(
  input  hit_t hit_i,
  output alu_e alu_op_o,
  output logic b_imm_o
);

  always_comb begin
    alu_op_o = ALU_ADD;
    if (hit_i[IX_SUB]) alu_op_o = ALU_SUB;
    if (hit_i[IX_AND]) alu_op_o = ALU_AND;
    if (hit_i[IX_OR])  alu_op_o = ALU_OR;
    if (hit_i[IX_NOT]) alu_op_o = ALU_NOT;
    b_imm_o = hit_i[IX_ADDI];
  end

endmodule

// File: rtl/isa_flow_ctl.sv
module isa_flow_ctl
  import isa_ctl_pkg::*;
(
  input  hit_t hit_i,
  output logic mem_we_o,
  output br_e  br_o,
  output jmp_e jmp_o,
  output fmt_e fmt_o
);

  always_comb begin
    mem_we_o = hit_i[IX_SW];

    br_o = BR_NONE;
    if (hit_i[IX_BZ])  br_o = BR_ZERO;
    if (hit_i[IX_BNZ]) br_o = BR_NONZERO;

    jmp_o = JMP_NONE;
    if (hit_i[IX_JAL]) jmp_o = JMP_REL8;
    if (hit_i[IX_J])   jmp_o = JMP_REL12;
    if (hit_i[IX_JR])  jmp_o = JMP_REG;

    fmt_o = FMT_R;
    if (hit_i[IX_ADDI] | hit_i[IX_LDHI] | hit_i[IX_BZ] |
        hit_i[IX_BNZ]  | hit_i[IX_JAL])
      fmt_o = FMT_I;
    if (hit_i[IX_J]) fmt_o = FMT_J;
  end

endmodule

// File: rtl/isa_ctl_decoder.sv
module isa_ctl_decoder
  import isa_ctl_pkg::*;
#(
  parameter int REG_IDX_W = 4,
  parameter int LINK_REG  = 1
) (
  input  logic [OPC_W-1:0]     opc_i,
  input  logic [REG_IDX_W-1:0] rd_i,
  output logic                 illegal_o,
  output logic                 reg_we_o,
  output logic [1:0]           wsrc_o,
  output logic [REG_IDX_W-1:0] wr_idx_o,
  output logic                 link_o,
  output logic [2:0]           alu_op_o,
  output logic                 b_imm_o,
  output logic                 mem_we_o,
  output logic [1:0]           br_o,
  output logic [1:0]           jmp_o,
  output logic [1:0]           fmt_o
);

  hit_t  hit;
  wsrc_e wsrc;
  alu_e  alu_op;
  br_e   br;
  jmp_e  jmp;
  fmt_e  fmt;

  isa_opclass i_opclass (
    .opc_i     (opc_i),
    .hit_o     (hit),
    .illegal_o (illegal_o)
  );

  isa_wb_ctl #(
    .REG_IDX_W (REG_IDX_W),
    .LINK_REG  (LINK_REG)
  ) i_wb_ctl (
    .hit_i    (hit),
    .rd_i     (rd_i),
    .reg_we_o (reg_we_o),
    .wsrc_o   (wsrc),
    .link_o   (link_o),
    .wr_idx_o (wr_idx_o)
  );

  isa_alu_ctl i_alu_ctl (
    .hit_i    (hit),
    .alu_op_o (alu_op),
    .b_imm_o  (b_imm_o)
  );

  isa_flow_ctl i_flow_ctl (
    .hit_i    (hit),
    .mem_we_o (mem_we_o),
    .br_o     (br),
    .jmp_o    (jmp),
    .fmt_o    (fmt)
  );

  assign wsrc_o   = wsrc;
  assign alu_op_o = alu_op;
  assign br_o     = br;
  assign jmp_o    = jmp;
  assign fmt_o    = fmt;

  // cross-checks between the separately decoded control groups
  always_comb begin
    if (!$isunknown(opc_i)) begin
      assert_illegal_quiet_R2: assert (!illegal_o ||
        (!reg_we_o && !mem_we_o && br == BR_NONE && jmp == JMP_NONE && !link_o))
        else $error("illegal opcode produced side effects");
      assert_store_no_regwr_R7: assert (!(mem_we_o && reg_we_o))
        else $error("store also writes a register");
      assert_imm_to_alu_R6: assert (!b_imm_o || (reg_we_o && wsrc == WSRC_ALU))
        else $error("immediate operand without ALU writeback");
      assert_link_target_R10: assert (!link_o ||
        (wsrc == WSRC_PC1 && jmp == JMP_REL8 && wr_idx_o == REG_IDX_W'(LINK_REG)))
        else $error("link without PC+1 to link register");
      assert_branch_exclusive_R8: assert (br == BR_NONE || (jmp == JMP_NONE && !reg_we_o))
        else $error("branch overlaps jump or register write");
      assert_jump_format_R9: assert (jmp != JMP_REL12 || fmt == FMT_J)
        else $error("long jump not J-format");
    end
  end

endmodule

// File: tb/test_isa_ctl_decoder.sv
`timescale 1ns/1ps
module test_isa_ctl_decoder;

  typedef struct packed {
    logic [3:0] opc;
    logic [3:0] rd;
    logic       ill;
    logic       we;
    logic [1:0] wsrc;
    logic [3:0] widx;
    logic       lnk;
    logic [2:0] alu;
    logic       bimm;
    logic       mwe;
    logic [1:0] br;
    logic [1:0] jmp;
    logic [1:0] fmt;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] opc = 4'h0;
  logic [3:0] rd  = 4'h0;

  logic       illegal, reg_we, b_imm, mem_we, link;
  logic [1:0] wsrc, br, jmp, fmt;
  logic [3:0] wr_idx;
  logic [2:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  isa_ctl_decoder i_isa_ctl_decoder (
    .opc_i     (opc),
    .rd_i      (rd),
    .illegal_o (illegal),
    .reg_we_o  (reg_we),
    .wsrc_o    (wsrc),
    .wr_idx_o  (wr_idx),
    .link_o    (link),
    .alu_op_o  (alu_op),
    .b_imm_o   (b_imm),
    .mem_we_o  (mem_we),
    .br_o      (br),
    .jmp_o     (jmp),
    .fmt_o     (fmt)
  );

  function automatic exp_t model(logic [3:0] o, logic [3:0] r);
    exp_t e;
    e = '0;
    e.opc = o; e.rd = r; e.widx = r;
    case (o)
      4'h0: e.we = 1;
      4'h1: begin e.we = 1; e.alu = 3'd1; end
      4'h2: begin e.we = 1; e.wsrc = 2'd1; end
      4'h3: e.mwe = 1;
      4'h4: begin e.we = 1; e.alu = 3'd2; end
      4'h5: begin e.we = 1; e.alu = 3'd3; end
      4'h6: begin e.we = 1; e.alu = 3'd4; end
      4'h8: begin e.we = 1; e.bimm = 1; e.fmt = 2'd1; end
      4'h9: begin e.we = 1; e.wsrc = 2'd3; e.fmt = 2'd1; end
      4'hA: begin e.br = 2'd1; e.fmt = 2'd1; end
      4'hB: begin e.br = 2'd2; e.fmt = 2'd1; end
      4'hD: begin e.we = 1; e.wsrc = 2'd2; e.jmp = 2'd1; e.lnk = 1;
                  e.widx = 4'd1; e.fmt = 2'd1; end
      4'hE: e.jmp = 2'd3;
      4'hF: begin e.jmp = 2'd2; e.fmt = 2'd2; end
      default: e.ill = 1;
    endcase
    return e;
  endfunction

  task automatic chk(string req, logic [3:0] o, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s opc=%h actual=%0d expected=%0d", req, o, act, expv);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [3:0] r);
    @(posedge clk);
    #1;
    opc = o;
    rd  = r;
    q.push_back(model(o, r));
  endtask

  // monitor: compare each pushed item at the following falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk("R1",  e.opc, illegal, e.ill);
        if (e.ill) chk("R2 quiet", e.opc, {reg_we, mem_we, link, br, jmp, wsrc, alu_op, b_imm, fmt}, 0);
        chk("R3",  e.opc, reg_we, e.we);
        chk("R4",  e.opc, wsrc,   e.wsrc);
        chk("R5",  e.opc, alu_op, e.alu);
        chk("R6",  e.opc, b_imm,  e.bimm);
        chk("R7",  e.opc, mem_we, e.mwe);
        chk("R8",  e.opc, br,     e.br);
        chk("R9",  e.opc, jmp,    e.jmp);
        chk("R10 link", e.opc, link,   e.lnk);
        chk("R10 idx",  e.opc, wr_idx, e.widx);
        chk("R11", e.opc, fmt,    e.fmt);
      end
    end
  end

  initial begin
    // reset-time state: inputs held at zero decode as add into rd 0
    #3;
    chk("R3 reset", opc, reg_we, 1);
    chk("R1 reset", opc, illegal, 0);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int r = 0; r < 4; r++) begin
      for (int o = 0; o < 16; o++) begin
        logic [3:0] rv;
        rv = (r == 0) ? 4'd0 : (r == 1) ? 4'd1 : (r == 2) ? 4'd6 : 4'd15;
        drive(o[3:0], rv);
      end
    end
    // back-to-back link / illegal / store transitions
    drive(4'hD, 4'h9);
    drive(4'h7, 4'h9);
    drive(4'hC, 4'h1);
    drive(4'h3, 4'hD);
    drive(4'hD, 4'h0);
    wait (q.size() == 0);
    @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule